// File: doc/BRIEF.md
# Six-Step Hall-Angle Commutation Generator

This block turns a 12-bit mechanical shaft angle into the three block-commutation signals `u`, `v` and `w` that drive a brushless motor. The pole-pair count can be set from 1 to 16. The block multiplies the angle by that count to get the electrical angle, divides one electrical turn into six 60° sectors, and drives the matching step of the six-step sequence.

A small mechanical window of 8 counts (about 0.7° out of 4096) keeps the outputs from chattering when the shaft rests on a sector edge. A configuration bit chooses where the angle comes from. It can come from a slow converter that has its own update strobe, or from a fast, low-latency angle input. Only strobes from the selected source are used.

Top module: `uvw_comm_gen`

## Requirements
- R1: The nominal sector of angle m is floor(((m × (pp_code+1)) mod 4096) × 6 / 4096). `pp_code` 0 gives 1 pole pair and 15 gives 16 pole pairs.
- R2: The sectors 0, 1, 2, 3, 4 and 5 drive {u,v,w} = 100, 110, 010, 011, 001 and 101 respectively.
- R3: While synchronous active-high `rst` is asserted, {u,v,w} becomes 100, and {u,v,w} never shows 000 or 111.
- R4: When `sync_off` = 0, only `conv_vld` strobes, carrying `conv_angle`, update the outputs. `fast_vld` has no effect.
- R5: When `sync_off` = 1, only `fast_vld` strobes, carrying `fast_angle`, update the outputs. `conv_vld` has no effect.
- R6: The outputs change on the clock edge that samples an accepted strobe and are visible after that edge. Without an accepted strobe they hold.
- R7: The first accepted sample after reset loads the nominal sector directly, with no hysteresis applied.
- R8: On every later sample, the held sector is kept if it equals the nominal sector of m−8, m or m+8 (angles wrap mod 4096). Otherwise the sector becomes the nominal sector of m. For example, with one pole pair and the sector 0/1 edge at 683, forward travel switches at 691 and backward travel switches at 674.
- R9: If `pp_code` or `sync_off` differs from its value at the previous accepted sample, that sample loads the nominal sector with no hysteresis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_angle | input | 12 | Low-latency mechanical angle |
| fast_vld | input | 1 | Strobe for fast_angle |
| conv_angle | input | 12 | Converter mechanical angle |
| conv_vld | input | 1 | Converter update strobe |
| pp_code | input | 4 | Pole pairs minus one |
| sync_off | input | 1 | 1 selects the fast path, 0 the converter path |
| u | output | 1 | Phase U commutation |
| v | output | 1 | Phase V commutation |
| w | output | 1 | Phase W commutation |

## Verification
The hardest state to reach is a held sector that disagrees with the nominal sector of the present angle, because only a walk across an edge creates it. The stimulus approaches the edge at 683 from below, stops 7 counts past it, steps one count further, and then walks back past the edge. In the second case the stimulus first leaves a sector held inside the window and then flips `sync_off`, so the next sample must ignore the hysteresis. A first sample at 690 straight after reset tells the no-hysteresis start apart from the windowed rule.

// File: rtl/uvw_pkg.sv
package uvw_pkg;
  typedef logic [2:0] sector_t;

  // Six-step table: exactly one phase toggles between neighbouring sectors
  function automatic logic [2:0] sector_to_uvw(input sector_t s);
    case (s)
      3'd0:    return 3'b100;
      3'd1:    return 3'b110;
      3'd2:    return 3'b010;
      3'd3:    return 3'b011;
      3'd4:    return 3'b001;
      default: return 3'b101;
    endcase
  endfunction
endpackage

// File: rtl/uvw_sample_mux.sv
module uvw_sample_mux #(
  parameter int ANG_W = 12
) (
  input  logic             sel_fast,
  input  logic [ANG_W-1:0] fast_angle,
  input  logic             fast_vld,
  input  logic [ANG_W-1:0] conv_angle,
  input  logic             conv_vld,
  output logic [ANG_W-1:0] smp_angle,
  output logic             smp_vld
);
  always_comb begin
    if (sel_fast) begin
      smp_angle = fast_angle;
      smp_vld   = fast_vld;
    end else begin
      smp_angle = conv_angle;
      smp_vld   = conv_vld;
    end
  end
endmodule

// File: rtl/uvw_sector.sv
module uvw_sector
  import uvw_pkg::*;
#(
  parameter int ANG_W = 12,
  parameter int PP_W  = 4,
  parameter int OFFS  = 0
) (
  input  logic [ANG_W-1:0] angle,
  input  logic [PP_W-1:0]  pp_code,
  output sector_t          sec
);
  localparam int              ELW   = ANG_W + 3;
  localparam logic [ANG_W-1:0] OFF_V = ANG_W'(OFFS);

  logic [ANG_W-1:0] mech;
  logic [PP_W:0]    ppn;
  logic [ANG_W-1:0] elec;

  assign mech = angle + OFF_V;
  assign ppn  = {1'b0, pp_code} + 1'b1;
  assign elec = ANG_W'(mech * ppn);
  assign sec  = 3'((ELW'(elec) * ELW'(6)) >> ANG_W);
endmodule

// File: rtl/uvw_comm_gen.sv
module uvw_comm_gen
  import uvw_pkg::*;
#(
  parameter int ANG_W = 12,
  parameter int PP_W  = 4,
  parameter int HYST  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ANG_W-1:0] fast_angle,
  input  logic             fast_vld,
  input  logic [ANG_W-1:0] conv_angle,
  input  logic             conv_vld,
  input  logic [PP_W-1:0]  pp_code,
  input  logic             sync_off,
  output logic             u,
  output logic             v,
  output logic             w
);
  localparam int NPT = 3;

  logic [ANG_W-1:0] smp_angle;
  logic             smp_vld;
  sector_t          pt_sec [NPT];
  sector_t          held_sec, next_sec;
  logic             primed, dcs_q;
  logic [PP_W-1:0]  pp_q;
  logic             keep;

  uvw_sample_mux #(.ANG_W(ANG_W)) i_mux (
    .sel_fast  (sync_off),
    .fast_angle(fast_angle),
    .fast_vld  (fast_vld),
    .conv_angle(conv_angle),
    .conv_vld  (conv_vld),
    .smp_angle (smp_angle),
    .smp_vld   (smp_vld)
  );

  // Probe points at -HYST, 0 and +HYST around the sampled angle
  for (genvar i = 0; i < NPT; i++) begin : g_pt
    uvw_sector #(.ANG_W(ANG_W), .PP_W(PP_W), .OFFS((i - 1) * HYST)) i_sec (
      .angle  (smp_angle),
      .pp_code(pp_code),
      .sec    (pt_sec[i])
    );
  end

  always_comb begin
    keep = 1'b0;
    for (int i = 0; i < NPT; i++)
      if (pt_sec[i] == held_sec) keep = 1'b1;
    if (!primed || pp_q != pp_code || dcs_q != sync_off) keep = 1'b0;
    next_sec = keep ? held_sec : pt_sec[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_sec    <= '0;
      primed      <= 1'b0;
      pp_q        <= '0;
      dcs_q       <= 1'b0;
      {u, v, w}   <= 3'b100;
    end else if (smp_vld) begin
      held_sec    <= next_sec;
      primed      <= 1'b1;
      pp_q        <= pp_code;
      dcs_q       <= sync_off;
      {u, v, w}   <= sector_to_uvw(next_sec);
    end
  end
endmodule

// File: rtl/uvw_comm_chk.sv
module uvw_comm_chk (
  input logic clk,
  input logic rst,
  input logic fast_vld,
  input logic conv_vld,
  input logic sync_off,
  input logic u,
  input logic v,
  input logic w
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  AST_LEGAL_PATTERN: assert property (@(posedge clk) disable iff (rst)
    ({u, v, w} != 3'b000) && ({u, v, w} != 3'b111));                      // R3

  always @(posedge clk)
    if (rst_q) AST_RESET_STEP: assert ({u, v, w} == 3'b100);               // R3

  AST_CONV_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!sync_off && !conv_vld) |=> $stable({u, v, w}));                      // R4

  AST_FAST_ONLY: assert property (@(posedge clk) disable iff (rst)
    (sync_off && !fast_vld) |=> $stable({u, v, w}));                       // R5
endmodule

bind uvw_comm_gen uvw_comm_chk i_chk (.*);

// File: tb/test_uvw_comm_gen.sv
module test_uvw_comm_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] fast_angle = '0, conv_angle = '0;
  logic        fast_vld = 1'b0, conv_vld = 1'b0;
  logic [3:0]  pp_code = '0;
  logic        sync_off = 1'b0;
  logic        u, v, w;

  int n_chk = 0, n_err = 0;
  int m_held = 0; bit m_primed = 0; int m_pp = 0; bit m_dcs = 0;

  always #5 clk = ~clk;

  uvw_comm_gen i_uvw_comm_gen (.*);

  function automatic int bsec(int m, int code);
    int e;
    e = ((m & 4095) * (code + 1)) % 4096;
    return (e * 6) / 4096;
  endfunction

  function automatic logic [2:0] benc(int s);
    logic [2:0] t [6] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
    return t[s];
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if ({u, v, w} !== exp) begin
      n_err++;
      $display("FAIL %s: uvw=%b expected %b", req, {u, v, w}, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_primed = 0; m_held = 0;
  endtask

  // Drive one strobe on the chosen path; model follows R7/R8/R9
  task automatic sample(input bit on_fast, input int a);
    int n;
    @(negedge clk);
    if (on_fast) begin fast_angle = 12'(a); fast_vld = 1'b1; end
    else         begin conv_angle = 12'(a); conv_vld = 1'b1; end
    if (on_fast == sync_off) begin
      n = bsec(a, pp_code);
      if (!m_primed || m_pp != pp_code || m_dcs != sync_off ||
          !(bsec(a - 8, pp_code) == m_held || n == m_held || bsec(a + 8, pp_code) == m_held))
        m_held = n;
      m_primed = 1; m_pp = pp_code; m_dcs = sync_off;
    end
    @(negedge clk);
    fast_vld = 1'b0; conv_vld = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    check("R3 reset", 3'b100);
  endtask

  task automatic t_first;
    pp_code = 0; sync_off = 0; do_reset();
    sample(0, 690); check("R7 first sample nominal", 3'b110);
  endtask

  task automatic t_encode;
    int ang [6] = '{341, 1024, 1707, 2389, 3072, 3755};
    logic [2:0] pat [6] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
    pp_code = 0; sync_off = 0; do_reset();
    for (int i = 0; i < 6; i++) begin
      sample(0, ang[i]); check("R2 sector pattern", pat[i]);
    end
  endtask

  task automatic t_hyst;
    pp_code = 0; sync_off = 0; do_reset();
    sample(0, 600); check("R8 start", 3'b100);
    sample(0, 690); check("R8 inside window fwd", 3'b100);
    sample(0, 691); check("R8 fwd switch at edge+8", 3'b110);
    sample(0, 683); check("R8 reverse holds", 3'b110);
    sample(0, 674); check("R8 back switch at edge-9", 3'b100);
    sample(0, 675); check("R8 no chatter", 3'b100);
  endtask

  task automatic t_pp;
    pp_code = 0; sync_off = 0; do_reset();
    sample(0, 50);
    pp_code = 4'hF;
    sample(0, 100); check("R1 R9 16 pole pairs", 3'b010);
    for (int a = 0; a < 4096; a += 61) begin
      sample(0, a); check("R1 sweep 16 pp", benc(m_held));
    end
    pp_code = 4'h4;
    for (int a = 4000; a > 0; a -= 97) begin
      sample(0, a); check("R1 sweep 5 pp backward", benc(m_held));
    end
  endtask

  task automatic t_paths;
    pp_code = 0; sync_off = 0; do_reset();
    sample(0, 341); check("R4 conv path", 3'b100);
    sample(1, 2389); check("R4 fast ignored", 3'b100);
    sync_off = 1;
    sample(1, 1707); check("R5 fast path", 3'b010);
    sample(0, 3755); check("R5 conv ignored", 3'b010);
  endtask

  task automatic t_timing;
    pp_code = 0; sync_off = 0; do_reset();
    sample(0, 341);
    @(negedge clk); conv_angle = 12'd3072; conv_vld = 1'b1;
    #1 check("R6 before edge", 3'b100);
    @(posedge clk); #1 check("R6 after edge", 3'b001);
    @(negedge clk); conv_vld = 1'b0;
    @(negedge clk); check("R6 holds", 3'b001);
  endtask

  task automatic t_cfg;
    pp_code = 0; sync_off = 0; do_reset();
    sample(0, 600); sample(0, 690); check("R9 held in window", 3'b100);
    sync_off = 1;
    sample(1, 690); check("R9 cfg change nominal", 3'b110);
  endtask

  initial begin
    t_reset(); t_first(); t_encode(); t_hyst(); t_pp(); t_paths(); t_timing(); t_cfg();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule